// File: doc/BRIEF.md
# Command-Port Watchdog Timer

This block is a watchdog timer that a host drives through two byte-wide addresses. Address 0 is a data register and address 1 is a command register. The host writes single-byte commands to the command register. These commands start, stop or kick the watchdog, ask the block to identify itself, or open an indexed write. An indexed write loads the two 16-bit delays: the first data byte after the command picks the register and the second data byte is its value.

A prescaler divides the system clock into 100 ms ticks. After a start, the optional enable delay runs first, with its length counted in ticks. The reset delay then loads and counts down, and a kick reloads it. If the reset delay runs out, the block drives a reset pulse of a fixed number of clocks and then returns to the stopped state. The host is expected to leave at least 10 ms between accesses, so each port access is a one-cycle strobe.

Top module: `cmdport_wdog`

## Requirements
- R1: A read strobe at address 0 returns the value most recently stored at a known index. After reset it returns 0x00 and the reset output is low.
- R2: Writing 0x30 to address 1 makes the next read of address 0 return 0x95. The read after that returns the last stored value again.
- R3: Writing 0x89 to address 1 opens an indexed write: the next write to address 0 is the index and the write after it is the value. Index 0x5E and index 0x5F are the high and low bytes of the reset delay, which is 600 after reset. Index 0x58 and index 0x59 are the high and low bytes of the enable delay, which is 0 after reset.
- R4: A value written to any other index changes no delay and does not change the read-back value.
- R5: A command byte written before the value byte abandons the indexed write, and so does an unknown command byte, with no delay change. Data writes outside an indexed write are ignored.
- R6: One tick occurs every TICKS_PER_100MS clocks. The tick phase restarts whenever a start, or a kick during the countdown, takes effect.
- R7: With enable delay 0 and reset delay N, the reset output rises 1 + N*TICKS_PER_100MS clocks after the edge that samples a 0x28 write. A value of N = 0 behaves as N = 1.
- R8: With a nonzero enable delay H, that rise comes 1 + (H+N)*TICKS_PER_100MS clocks after the start edge.
- R9: Writing 0x2A during the countdown reloads the count, so the rise comes 1 + N*TICKS_PER_100MS clocks after the kick edge. A kick while stopped has no effect.
- R10: Writing 0x29 stops the watchdog, and no reset pulse follows.
- R11: The reset pulse lasts exactly PULSE_CLKS clocks. The watchdog is then stopped and gives no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_addr | input | 1 | 0 = data register, 1 = command register |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for address 0, valid while strobed |
| wdog_rst_o | output | 1 | Reset pulse on expiry |

## Verification
The register path is driven through a vector table. The table contains a plain indexed write, a write to an unknown index, a sequence broken off by a command, and a sequence broken off by an unknown command, and the read-back value tells each of these cases apart. Timing is checked by measuring the exact clock of the reset rise in four cases: a start with no enable delay, a start with an enable delay, a start followed by a kick, and a start followed by a stop. Each rise time separates the enable-delay, reload and prescaler-phase rules. The pulse width and the absence of a second pulse confirm the return to the stopped state.

// File: rtl/cpw_pkg.sv
// Shared constants and state encodings for the command-port watchdog.
// Assumes byte-wide host accesses and 16-bit delay registers.
package cpw_pkg;
    localparam int DLY_W = 16;

    localparam logic [7:0] CMD_PROBE  = 8'h30;
    localparam logic [7:0] CMD_IWRITE = 8'h89;
    localparam logic [7:0] CMD_START  = 8'h28;
    localparam logic [7:0] CMD_STOP   = 8'h29;
    localparam logic [7:0] CMD_KICK   = 8'h2A;

    localparam logic [7:0] IDX_EN_HI  = 8'h58;
    localparam logic [7:0] IDX_EN_LO  = 8'h59;
    localparam logic [7:0] IDX_RST_HI = 8'h5E;
    localparam logic [7:0] IDX_RST_LO = 8'h5F;

    localparam logic [7:0] SIGNATURE  = 8'h95;

    typedef enum logic [1:0] {SQ_IDLE, SQ_INDEX, SQ_VALUE} seq_t;
    typedef enum logic [1:0] {WD_STOP, WD_HOLD, WD_RUN, WD_PULSE} wd_state_t;
endpackage

// File: rtl/cpw_host_if.sv
// Host port decoder, command sequencer and delay register file.
// Assumes one-cycle strobes, spaced apart as the host guarantees.
// Command effects leave here as one-cycle registered pulses.
module cpw_host_if
    import cpw_pkg::*;
#(
    parameter logic [DLY_W-1:0] RST_DEFAULT = 16'd600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             addr_i,
    input  logic             wr_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o,
    output logic             start_o,
    output logic             stop_o,
    output logic             kick_o,
    output logic [DLY_W-1:0] en_dly_o,
    output logic [DLY_W-1:0] rst_dly_o
);
    seq_t             seq_q;
    logic [7:0]       idx_q;
    logic [7:0]       last_q;
    logic             probe_q;
    logic [DLY_W-1:0] en_dly_q;
    logic [DLY_W-1:0] rst_dly_q;

    logic cmd_wr, data_wr, data_rd, idx_known;

    // Classify the current access.
    always_comb begin
        cmd_wr    = sel_i && wr_i && addr_i;
        data_wr   = sel_i && wr_i && !addr_i;
        data_rd   = sel_i && !wr_i && !addr_i;
        idx_known = (idx_q == IDX_EN_HI) || (idx_q == IDX_EN_LO) ||
                    (idx_q == IDX_RST_HI) || (idx_q == IDX_RST_LO);
    end

    // Command decode, indexed-write sequencing and register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q     <= SQ_IDLE;
            idx_q     <= 8'h00;
            last_q    <= 8'h00;
            probe_q   <= 1'b0;
            en_dly_q  <= '0;
            rst_dly_q <= RST_DEFAULT;
            start_o   <= 1'b0;
            stop_o    <= 1'b0;
            kick_o    <= 1'b0;
        end else begin
            start_o <= 1'b0;
            stop_o  <= 1'b0;
            kick_o  <= 1'b0;
            if (cmd_wr) begin
                probe_q <= (wdata_i == CMD_PROBE);
                seq_q   <= (wdata_i == CMD_IWRITE) ? SQ_INDEX : SQ_IDLE;
                start_o <= (wdata_i == CMD_START);
                stop_o  <= (wdata_i == CMD_STOP);
                kick_o  <= (wdata_i == CMD_KICK);
            end else if (data_wr) begin
                case (seq_q)
                    SQ_INDEX: begin
                        idx_q <= wdata_i;
                        seq_q <= SQ_VALUE;
                    end
                    SQ_VALUE: begin
                        seq_q <= SQ_IDLE;
                        if (idx_known) last_q <= wdata_i;
                        case (idx_q)
                            IDX_EN_HI:  en_dly_q[15:8]  <= wdata_i;
                            IDX_EN_LO:  en_dly_q[7:0]   <= wdata_i;
                            IDX_RST_HI: rst_dly_q[15:8] <= wdata_i;
                            IDX_RST_LO: rst_dly_q[7:0]  <= wdata_i;
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end else if (data_rd) begin
                probe_q <= 1'b0;
            end
        end
    end

    // Read mux: signature while a probe is pending, else last stored byte.
    assign rdata_o   = probe_q ? SIGNATURE : last_q;
    assign en_dly_o  = en_dly_q;
    assign rst_dly_o = rst_dly_q;

    assert_probe_sig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata_i == CMD_PROBE) |=> (rdata_o == SIGNATURE));

    assert_idle_data_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && seq_q == SQ_IDLE) |=>
            ($stable(en_dly_o) && $stable(rst_dly_o) && $stable(last_q)));

    assert_unknown_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && seq_q == SQ_VALUE && !idx_known) |=>
            ($stable(en_dly_o) && $stable(rst_dly_o)));
endmodule

// File: rtl/cpw_tick.sv
// Prescaler producing one tick per TICKS clocks.
// A restart pulse realigns the phase so the first tick comes TICKS clocks later.
module cpw_tick #(
    parameter int TICKS = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Tick fires on the last count of each period.
    assign tick_o = (cnt_q == LAST);

    // Free-running divider with synchronous restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || tick_o) cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (TICKS > 1) begin : g_gap
            assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/cpw_countdown.sv
// Watchdog state machine: enable-delay hold, reset-delay countdown, reset pulse.
// Assumes at most one command pulse per cycle; a running pulse ignores commands.
module cpw_countdown
    import cpw_pkg::*;
#(
    parameter int PULSE_CLKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             kick_i,
    input  logic [DLY_W-1:0] en_dly_i,
    input  logic [DLY_W-1:0] rst_dly_i,
    output logic             restart_o,
    output logic             wdog_rst_o
);
    localparam int PW = $clog2(PULSE_CLKS + 1);

    wd_state_t        st_q;
    logic [DLY_W-1:0] cnt_q;
    logic [PW-1:0]    pc_q;
    logic             counting;

    // Counting covers the hold and run phases.
    assign counting   = (st_q == WD_HOLD) || (st_q == WD_RUN);
    // Prescaler realigns on any start, or a kick that reloads the countdown.
    assign restart_o  = (start_i && st_q != WD_PULSE) || (kick_i && st_q == WD_RUN);
    assign wdog_rst_o = (st_q == WD_PULSE);

    // Phase sequencing and countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WD_STOP;
            cnt_q <= '0;
            pc_q  <= '0;
        end else begin
            case (st_q)
                WD_STOP: begin
                    if (start_i) begin
                        st_q  <= (en_dly_i == '0) ? WD_RUN : WD_HOLD;
                        cnt_q <= (en_dly_i == '0) ? rst_dly_i : en_dly_i;
                    end
                end
                WD_HOLD, WD_RUN: begin
                    if (stop_i) begin
                        st_q <= WD_STOP;
                    end else if (start_i) begin
                        st_q  <= (en_dly_i == '0) ? WD_RUN : WD_HOLD;
                        cnt_q <= (en_dly_i == '0) ? rst_dly_i : en_dly_i;
                    end else if (kick_i && st_q == WD_RUN) begin
                        cnt_q <= rst_dly_i;
                    end else if (tick_i) begin
                        if (cnt_q <= DLY_W'(1)) begin
                            if (st_q == WD_HOLD) begin
                                st_q  <= WD_RUN;
                                cnt_q <= rst_dly_i;
                            end else begin
                                st_q <= WD_PULSE;
                                pc_q <= PW'(PULSE_CLKS - 1);
                            end
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                default: begin
                    if (pc_q == '0) st_q <= WD_STOP;
                    else            pc_q <= pc_q - 1'b1;
                end
            endcase
        end
    end

    assert_rise_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst_o) |-> $past(tick_i));

    assert_stop_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && counting) |=> (st_q == WD_STOP && !wdog_rst_o));

    assert_kick_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i && st_q == WD_RUN && !stop_i && !start_i) |=> (cnt_q == $past(rst_dly_i)));

    assert_pulse_ends_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog_rst_o) |-> (st_q == WD_STOP));
endmodule

// File: rtl/cmdport_wdog.sv
// Top level of the command-port watchdog: host port, prescaler, countdown.
// Assumes the host spaces accesses well apart; no edge buffering is present.
module cmdport_wdog #(
    parameter int TICKS_PER_100MS = 10_000_000,
    parameter int PULSE_CLKS      = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wdog_rst_o
);
    import cpw_pkg::*;

    logic             start_p, stop_p, kick_p, tick, restart;
    logic [DLY_W-1:0] en_dly, rst_dly;

    cpw_host_if u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (bus_sel),
        .addr_i    (bus_addr),
        .wr_i      (bus_wr),
        .wdata_i   (bus_wdata),
        .rdata_o   (bus_rdata),
        .start_o   (start_p),
        .stop_o    (stop_p),
        .kick_o    (kick_p),
        .en_dly_o  (en_dly),
        .rst_dly_o (rst_dly)
    );

    cpw_tick #(.TICKS(TICKS_PER_100MS)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .tick_o    (tick)
    );

    cpw_countdown #(.PULSE_CLKS(PULSE_CLKS)) u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .start_i    (start_p),
        .stop_i     (stop_p),
        .kick_i     (kick_p),
        .en_dly_i   (en_dly),
        .rst_dly_i  (rst_dly),
        .restart_o  (restart),
        .wdog_rst_o (wdog_rst_o)
    );
endmodule

// File: tb/cmdport_wdog_tb.sv
// Self-checking bench: vector table for the register path, directed timing tests.
module cmdport_wdog_tb;
    localparam int T = 8;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdog_rst_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_edge = 0;
    int rises = 0;
    int rise_cyc = 0;
    int hi_cnt = 0;
    logic prev_rst = 1'b0;
    logic done = 1'b0;

    cmdport_wdog #(.TICKS_PER_100MS(T), .PULSE_CLKS(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_rst_o(wdog_rst_o)
    );

    always #2.5 clk = ~clk;

    // Edge counter; read at negedges only.
    always @(posedge clk) cyc <= cyc + 1;

    // Reset-pulse monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (wdog_rst_o && !prev_rst) begin
            rises    = rises + 1;
            rise_cyc = cyc;
        end
        if (wdog_rst_o) hi_cnt = hi_cnt + 1;
        prev_rst = wdog_rst_o;
    end

    // Vector: {chk, wr, addr, data[7:0], exp[7:0]}
    localparam int NV = 22;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h00},  // R1 reset read-back
        {1'b0, 1'b1, 1'b1, 8'h30, 8'h00},  // R2 probe
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h95},
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'h89, 8'h00},  // R3 reset-delay low = 3
        {1'b0, 1'b1, 1'b0, 8'h5F, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'h03, 8'h00},
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h03},
        {1'b0, 1'b1, 1'b1, 8'h89, 8'h00},  // R4 unknown index
        {1'b0, 1'b1, 1'b0, 8'h77, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'hAA, 8'h00},
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h03},
        {1'b0, 1'b1, 1'b1, 8'h89, 8'h00},  // R5 abort by stop command
        {1'b0, 1'b1, 1'b0, 8'h5E, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'h29, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'h11, 8'h00},
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h03},
        {1'b0, 1'b1, 1'b1, 8'h89, 8'h00},  // R5 abort by unknown command
        {1'b0, 1'b1, 1'b0, 8'h58, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'h55, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'h22, 8'h00},
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h03}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobed access; returns read data sampled before the edge.
    task automatic access(input logic wr, input logic addr, input logic [7:0] d,
                          output logic [7:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = d;
        #1 rd = bus_rdata;
        @(negedge clk);
        last_edge = cyc;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [7:0] c);
        logic [7:0] rd;
        access(1'b1, 1'b1, c, rd);
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] v);
        logic [7:0] rd;
        access(1'b1, 1'b1, 8'h89, rd);
        access(1'b1, 1'b0, idx, rd);
        access(1'b1, 1'b0, v, rd);
    endtask

    task automatic clear_mon();
        @(negedge clk);
        rises = 0; hi_cnt = 0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wdog_rst_o == 1'b0, "R1 reset output low", int'(wdog_rst_o), 0);

        // Register path walked from the table (R1 R2 R3 R4 R5).
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][17], VEC[i][16], VEC[i][15:8], rd);
            if (VEC[i][18])
                check(rd == VEC[i][7:0], $sformatf("R1 R2 R3 R4 R5 table step %0d", i),
                      int'(rd), int'(VEC[i][7:0]));
        end

        // Reset delay = 3 ticks (high byte cleared), enable delay still 0.
        wr_reg(8'h5E, 8'h00);

        // R7 plain start, R11 pulse width and single pulse.
        clear_mon();
        wr_cmd(8'h28);
        e = last_edge;
        repeat (3 * T + 3 * P + 40) @(negedge clk);
        check(rises == 1, "R7 one pulse", rises, 1);
        check(rise_cyc == e + 1 + 3 * T, "R7 rise time", rise_cyc - e, 1 + 3 * T);
        check(hi_cnt == P, "R11 pulse width", hi_cnt, P);

        // R9 kick during countdown reloads and realigns the tick.
        clear_mon();
        wr_cmd(8'h28);
        repeat (2 * T - 4) @(negedge clk);
        wr_cmd(8'h2A);
        e = last_edge;
        repeat (3 * T + 3 * P + 20) @(negedge clk);
        check(rises == 1, "R9 kick one pulse", rises, 1);
        check(rise_cyc == e + 1 + 3 * T, "R9 kick rise time", rise_cyc - e, 1 + 3 * T);

        // R10 stop halts the countdown.
        clear_mon();
        wr_cmd(8'h28);
        repeat (T) @(negedge clk);
        wr_cmd(8'h29);
        repeat (6 * T) @(negedge clk);
        check(rises == 0, "R10 no pulse after stop", rises, 0);

        // R9 kick while stopped has no effect.
        wr_cmd(8'h2A);
        repeat (6 * T) @(negedge clk);
        check(rises == 0, "R9 kick while stopped", rises, 0);

        // R8 enable delay of 2 ticks ahead of the 3-tick countdown.
        wr_reg(8'h59, 8'h02);
        access(1'b0, 1'b0, 8'h00, rd);
        check(rd == 8'h02, "R3 enable-delay read-back", int'(rd), 2);
        clear_mon();
        wr_cmd(8'h28);
        e = last_edge;
        repeat (5 * T + P + 60) @(negedge clk);
        check(rises == 1, "R11 single pulse then stopped", rises, 1);
        check(rise_cyc == e + 1 + 5 * T, "R8 rise time", rise_cyc - e, 1 + 5 * T);
        check(hi_cnt == P, "R11 pulse width with hold", hi_cnt, P);

        // R7 zero reset delay behaves as one tick.
        wr_reg(8'h59, 8'h00);
        wr_reg(8'h5F, 8'h00);
        clear_mon();
        wr_cmd(8'h28);
        e = last_edge;
        repeat (T + P + 20) @(negedge clk);
        check(rise_cyc == e + 1 + T, "R7 zero delay rise time", rise_cyc - e, 1 + T);
        check(rises == 1, "R7 zero delay one pulse", rises, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule